// File: doc/BRIEF.md
# Four-State Snooping Coherence Line Controller

This block tracks the coherence state of every line of one private, direct-mapped cache that sits on a shared snooping bus. It accepts load and store requests from its processor and looks each one up against a per-line tag and state. A request either completes at once or drives one or two bus transactions through a request/grant handshake. In parallel, the block watches the transactions that other caches place on the bus. When one of them names a line it holds, it changes that line's state, and it may signal that it shares the line or supply the dirty data.

Each line is in one of four states: Invalid, Shared (clean, possibly held elsewhere), Exclusive (clean, held only here) and Modified (dirty, held only here). The Exclusive state lets a store to a clean private line proceed with no bus traffic. A store to a Shared line must first broadcast an invalidation. The data arrays and the bus arbiter are outside the block.

The processor holds its request (valid, write, address) stable until `cpu_done` pulses. The bus never grants this controller in a cycle in which it also presents a snooped transaction. Bus and snoop command codes are 0 = write-back, 1 = read, 2 = read-for-ownership, 3 = invalidate. The line index is the low `IDX_W` bits of a line address, and the tag is the remaining upper bits.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `cpu_done`, `snp_shared`, `snp_supply` and `snp_mem_wb` are all low.
- R2: A read that misses raises `bus_req` with command 1 (read) and the request address. In the grant cycle `cpu_done` pulses and the line is filled Exclusive if `bus_shared_in` is low, or Shared if it is high.
- R3: A read that hits a valid line pulses `cpu_done` in the cycle it is presented, with no bus request.
- R4: A write that hits an Exclusive or Modified line pulses `cpu_done` in the cycle it is presented, with no bus request, and leaves the line Modified.
- R5: A write that hits a Shared line issues command 3 (invalidate) for the line, pulses `cpu_done` in the grant cycle and leaves the line Modified.
- R6: A write that misses issues command 2 (read-for-ownership), pulses `cpu_done` in the grant cycle and leaves the line Modified.
- R7: A miss on an index whose line is Modified with another tag first issues command 0 (write-back) at the old line address, which invalidates the line. It then issues the fill command for the new address.
- R8: A snooped read that hits a Modified line raises `snp_supply` and `snp_mem_wb` and moves the line to Shared. If it hits an Exclusive or Shared line it raises `snp_shared`, and the line ends Shared.
- R9: A snooped read-for-ownership or invalidate that hits a valid line moves it to Invalid and raises `snp_supply` only if the line was Modified.
- R10: A snooped write-back, or any snoop whose tag does not match the line, produces no response and leaves the line unchanged.
- R11: If a pending invalidate loses its line to a snoop before the grant, the request turns into a read-for-ownership.
- R12: Once raised, `bus_req` stays high until `bus_gnt`.
- R13: A processor request presented in a cycle with `snp_valid` high is not completed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | Command of the requested transaction |
| bus_addr | output | ADDR_W | Line address of the requested transaction |
| bus_gnt | input | 1 | Transaction performed this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (valid with grant) |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the snooped line clean |
| snp_supply | output | 1 | This cache supplies dirty data |
| snp_mem_wb | output | 1 | Supplied data is also written to memory |

## Verification
On every cycle the checker confirms several properties. The bus request is held until granted. Shared and supply responses never coincide, and supply occurs only from a Modified line. A read fill lands in Exclusive or Shared according to the sampled shared signal, and completed stores leave their line Modified. A snooped ownership or invalidate hit clears the line, and a granted write-back empties the line and keeps the request raised for the fill. Some behaviour depends on a chain of states, and only the bench scenarios show it. These cover the silent Exclusive-to-Modified store against the invalidate from Shared, victim write-back ordering and addresses, snoops that must change nothing, and a pending invalidate turned into read-for-ownership by an intervening snoop.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_WB  = 2'd0,
    CMD_RD  = 2'd1,
    CMD_RDX = 2'd2,
    CMD_INV = 2'd3
  } bus_cmd_t;

  typedef struct packed {
    logic shared;
    logic supply;
    logic mem_wb;
  } snp_rsp_t;

  // a processor access must go to the bus unless it hits with enough rights
  function automatic logic needs_bus(line_st_t st, logic hit, logic wr);
    return !hit || (wr && st == ST_S);
  endfunction

  // bus command for an access that needs the bus
  function automatic bus_cmd_t pick_cmd(line_st_t st, logic hit, logic wr);
    if (!hit && st == ST_M) return CMD_WB;
    if (wr) return (hit && st == ST_S) ? CMD_INV : CMD_RDX;
    return CMD_RD;
  endfunction

  // state left in the line when our own transaction is granted
  function automatic line_st_t fill_state(bus_cmd_t cmd, logic shared_in);
    case (cmd)
      CMD_RD:          return shared_in ? ST_S : ST_E;
      CMD_RDX, CMD_INV: return ST_M;
      default:         return ST_I;
    endcase
  endfunction

  // state after a snooped transaction hits the line
  function automatic line_st_t snoop_next(line_st_t st, bus_cmd_t cmd);
    case (cmd)
      CMD_RD:           return (st == ST_I) ? ST_I : ST_S;
      CMD_RDX, CMD_INV: return ST_I;
      default:          return st;
    endcase
  endfunction

  // response driven while a snooped transaction hits the line
  function automatic snp_rsp_t snoop_rsp(line_st_t st, bus_cmd_t cmd);
    snp_rsp_t r;
    r = '0;
    case (cmd)
      CMD_RD: begin
        r.shared = (st == ST_E) || (st == ST_S);
        r.supply = (st == ST_M);
        r.mem_wb = (st == ST_M);
      end
      CMD_RDX, CMD_INV: r.supply = (st == ST_M);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      a_idx,
  output line_st_t              a_st,
  output logic [TAG_W-1:0]      a_tag,
  input  logic                  a_we,
  input  line_st_t              a_st_d,
  input  logic                  a_tag_we,
  input  logic [TAG_W-1:0]      a_tag_d,
  input  logic [IDX_W-1:0]      b_idx,
  output line_st_t              b_st,
  output logic [TAG_W-1:0]      b_tag,
  input  logic                  b_we,
  input  line_st_t              b_st_d,
  output logic [2*(1<<IDX_W)-1:0] st_flat
);
  localparam int LINES = 1 << IDX_W;

  line_st_t         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  assign a_st  = st_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign b_st  = st_q[b_idx];
  assign b_tag = tag_q[b_idx];

  // port b (snoop) is written last so it wins on the same index
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      if (a_we) begin
        st_q[a_idx] <= a_st_d;
        if (a_tag_we) tag_q[a_idx] <= a_tag_d;
      end
      if (b_we) st_q[b_idx] <= b_st_d;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_flat
    assign st_flat[2*g +: 2] = st_q[g];
  end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_t         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             hit,
  output snp_rsp_t         rsp,
  output logic             st_we,
  output line_st_t         st_next
);
  bus_cmd_t cmd;

  always_comb begin
    cmd     = bus_cmd_t'(snp_cmd);
    hit     = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
    st_next = snoop_next(line_st, cmd);
    rsp     = hit ? snoop_rsp(line_st, cmd) : '0;
    st_we   = hit && (st_next != line_st);
  end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              snp_valid,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  line_st_t          line_st,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  output logic [IDX_W-1:0]  look_idx,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              st_we,
  output line_st_t          st_d,
  output logic              tag_we,
  output logic [ADDR_W-IDX_W-1:0] tag_d
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic {RQ_IDLE, RQ_BUS} rq_t;

  rq_t               rq_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;

  logic              cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic              hit;
  logic              need;
  logic              accept;
  bus_cmd_t          cmd;

  always_comb begin
    cur_wr   = (rq_q == RQ_BUS) ? wr_q   : cpu_write;
    cur_addr = (rq_q == RQ_BUS) ? addr_q : cpu_addr;
    cur_tag  = cur_addr[ADDR_W-1:IDX_W];
    look_idx = cur_addr[IDX_W-1:0];
    hit      = (line_st != ST_I) && (line_tag == cur_tag);
    need     = needs_bus(line_st, hit, cur_wr);
    cmd      = pick_cmd(line_st, hit, cur_wr);
    accept   = (rq_q == RQ_IDLE) && cpu_valid && !snp_valid;

    bus_req  = (rq_q == RQ_BUS);
    bus_cmd  = cmd;
    bus_addr = (cmd == CMD_WB) ? {line_tag, look_idx} : cur_addr;

    cpu_done = 1'b0;
    st_we    = 1'b0;
    st_d     = ST_M;
    tag_we   = 1'b0;
    tag_d    = cur_tag;

    if (accept && !need) begin
      cpu_done = 1'b1;
      st_we    = cur_wr && (line_st != ST_M);
    end else if (bus_req && bus_gnt) begin
      st_we    = 1'b1;
      st_d     = fill_state(cmd, bus_shared_in);
      tag_we   = (cmd != CMD_WB);
      cpu_done = (cmd != CMD_WB);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_q   <= RQ_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else if (accept && need) begin
      rq_q   <= RQ_BUS;
      wr_q   <= cpu_write;
      addr_q <= cpu_addr;
    end else if (bus_req && bus_gnt && cmd != CMD_WB) begin
      rq_q   <= RQ_IDLE;
    end
  end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic              snp_mem_wb
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0]   req_idx;
  line_st_t           req_st;
  logic [TAG_W-1:0]   req_tag;
  logic               req_st_we;
  line_st_t           req_st_d;
  logic               req_tag_we;
  logic [TAG_W-1:0]   req_tag_d;

  line_st_t           snp_line_st;
  logic [TAG_W-1:0]   snp_line_tag;
  logic               snp_hit;
  snp_rsp_t           snp_rsp;
  logic               snp_st_we;
  line_st_t           snp_st_d;

  logic [2*LINES-1:0] st_flat;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_idx    (req_idx),
    .a_st     (req_st),
    .a_tag    (req_tag),
    .a_we     (req_st_we),
    .a_st_d   (req_st_d),
    .a_tag_we (req_tag_we),
    .a_tag_d  (req_tag_d),
    .b_idx    (snp_addr[IDX_W-1:0]),
    .b_st     (snp_line_st),
    .b_tag    (snp_line_tag),
    .b_we     (snp_st_we),
    .b_st_d   (snp_st_d),
    .st_flat  (st_flat)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
    .line_st   (snp_line_st),
    .line_tag  (snp_line_tag),
    .hit       (snp_hit),
    .rsp       (snp_rsp),
    .st_we     (snp_st_we),
    .st_next   (snp_st_d)
  );

  mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_valid     (cpu_valid),
    .cpu_write     (cpu_write),
    .cpu_addr      (cpu_addr),
    .snp_valid     (snp_valid),
    .bus_gnt       (bus_gnt),
    .bus_shared_in (bus_shared_in),
    .line_st       (req_st),
    .line_tag      (req_tag),
    .look_idx      (req_idx),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_cmd       (bus_cmd),
    .bus_addr      (bus_addr),
    .st_we         (req_st_we),
    .st_d          (req_st_d),
    .tag_we        (req_tag_we),
    .tag_d         (req_tag_d)
  );

  assign snp_shared = snp_rsp.shared;
  assign snp_supply = snp_rsp.supply;
  assign snp_mem_wb = snp_rsp.mem_wb;

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cpu_done,
  input logic                     cpu_write,
  input logic [ADDR_W-1:0]        cpu_addr,
  input logic                     bus_req,
  input logic [1:0]               bus_cmd,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_gnt,
  input logic                     bus_shared_in,
  input logic                     snp_valid,
  input logic [1:0]               snp_cmd,
  input logic [ADDR_W-1:0]        snp_addr,
  input logic                     snp_shared,
  input logic                     snp_supply,
  input logic                     snp_hit,
  input logic [2*(1<<IDX_W)-1:0]  st_flat
);
  logic [IDX_W-1:0] bus_idx_q, snp_idx_q, cpu_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_idx_q <= '0;
      snp_idx_q <= '0;
      cpu_idx_q <= '0;
    end else begin
      bus_idx_q <= bus_addr[IDX_W-1:0];
      snp_idx_q <= snp_addr[IDX_W-1:0];
      cpu_idx_q <= cpu_addr[IDX_W-1:0];
    end
  end

  wire [1:0] st_bus_q = st_flat[2*bus_idx_q +: 2];
  wire [1:0] st_snp_q = st_flat[2*snp_idx_q +: 2];
  wire [1:0] st_cpu_q = st_flat[2*cpu_idx_q +: 2];
  wire [1:0] st_snp   = st_flat[2*snp_addr[IDX_W-1:0] +: 2];

  p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);

  p_rsp_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_shared && snp_supply));

  p_supply_from_m_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> st_snp == ST_M);

  p_read_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == CMD_RD |=>
      st_bus_q == ($past(bus_shared_in) ? ST_S : ST_E));

  p_own_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_hit && (snp_cmd == CMD_RDX || snp_cmd == CMD_INV) |=>
      st_snp_q == ST_I);

  p_victim_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == CMD_WB |=> st_bus_q == ST_I && bus_req);

  p_store_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && cpu_write |=> st_cpu_q == ST_M);

  p_snoop_first_r13: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !bus_req |-> !cpu_done);

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_done      (cpu_done),
  .cpu_write     (cpu_write),
  .cpu_addr      (cpu_addr),
  .bus_req       (bus_req),
  .bus_cmd       (bus_cmd),
  .bus_addr      (bus_addr),
  .bus_gnt       (bus_gnt),
  .bus_shared_in (bus_shared_in),
  .snp_valid     (snp_valid),
  .snp_cmd       (snp_cmd),
  .snp_addr      (snp_addr),
  .snp_shared    (snp_shared),
  .snp_supply    (snp_supply),
  .snp_hit       (snp_hit),
  .st_flat       (st_flat)
);

// File: tb/mesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_test;
  localparam int AW = 12;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SN = 2'd2;
  localparam logic [1:0] C_WB = 2'd0, C_RD = 2'd1, C_RDX = 2'd2, C_INV = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_done, bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic bus_gnt = 1'b0, bus_shared_in = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_supply, snp_mem_wb;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mesi_snoop_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_mem_wb(snp_mem_wb)
  );

  // {op, scmd, addr, shin, n_cmds, cmd0, cmd1, addr0, resp{shared,supply,mem_wb}}
  function automatic logic [37:0] mk(logic [1:0] op, logic [1:0] sc, logic [11:0] a,
                                     logic sh, logic [1:0] n, logic [1:0] c0,
                                     logic [1:0] c1, logic [11:0] a0, logic [2:0] r);
    return {op, sc, a, sh, n, c0, c1, a0, r};
  endfunction

  localparam int NV = 23;
  localparam logic [37:0] VEC [NV] = '{
    mk(OP_RD, 0,     12'h010, 0, 1, C_RD,  0,     12'h010, 0), // R2 miss -> E
    mk(OP_RD, 0,     12'h010, 0, 0, 0,     0,     0,       0), // R3 hit
    mk(OP_SN, C_RD,  12'h010, 0, 0, 0,     0,     0,       4), // R8 E -> S, shared
    mk(OP_WR, 0,     12'h010, 0, 1, C_INV, 0,     12'h010, 0), // R5 S -> M by invalidate
    mk(OP_WR, 0,     12'h010, 0, 0, 0,     0,     0,       0), // R4 M hit
    mk(OP_SN, C_RD,  12'h010, 0, 0, 0,     0,     0,       3), // R8 M supply + mem wb
    mk(OP_SN, C_RD,  12'h010, 0, 0, 0,     0,     0,       4), // R8 now S
    mk(OP_RD, 0,     12'h021, 1, 1, C_RD,  0,     12'h021, 0), // R2 miss -> S
    mk(OP_WR, 0,     12'h021, 0, 1, C_INV, 0,     12'h021, 0), // R5 proves S fill
    mk(OP_RD, 0,     12'h032, 0, 1, C_RD,  0,     12'h032, 0), // R2 -> E
    mk(OP_WR, 0,     12'h032, 0, 0, 0,     0,     0,       0), // R4 silent E -> M
    mk(OP_SN, C_RDX, 12'h032, 0, 0, 0,     0,     0,       2), // R9 M supply -> I
    mk(OP_SN, C_RD,  12'h032, 0, 0, 0,     0,     0,       0), // R9 line gone
    mk(OP_WR, 0,     12'h043, 0, 1, C_RDX, 0,     12'h043, 0), // R6 write miss
    mk(OP_RD, 0,     12'h04B, 0, 2, C_WB,  C_RD,  12'h043, 0), // R7 victim first
    mk(OP_SN, C_RD,  12'h043, 0, 0, 0,     0,     0,       0), // R7 old line gone
    mk(OP_SN, C_INV, 12'h04B, 0, 0, 0,     0,     0,       0), // R9 E -> I, no supply
    mk(OP_RD, 0,     12'h04B, 0, 1, C_RD,  0,     12'h04B, 0), // R9 proves I
    mk(OP_SN, C_WB,  12'h04B, 0, 0, 0,     0,     0,       0), // R10 wb ignored
    mk(OP_SN, C_RD,  12'h14B, 0, 0, 0,     0,     0,       0), // R10 tag mismatch
    mk(OP_WR, 0,     12'h04B, 0, 0, 0,     0,     0,       0), // R10 still E
    mk(OP_WR, 0,     12'h055, 0, 1, C_RDX, 0,     12'h055, 0), // R6
    mk(OP_WR, 0,     12'h065, 0, 2, C_WB,  C_RDX, 12'h055, 0)  // R7 victim then RDX
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic cpu_op(input logic w, input logic [AW-1:0] a, input logic sh,
                        output int n, output logic [1:0] c0, output logic [1:0] c1,
                        output logic [AW-1:0] a0, output int cyc);
    logic done;
    done = 1'b0; n = 0; c0 = 0; c1 = 0; a0 = 0; cyc = 0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = w; cpu_addr = a;
    for (int k = 0; k < 20 && !done; k++) begin
      #1;
      if (bus_req) begin
        if (n == 0) begin c0 = bus_cmd; a0 = bus_addr; end
        else c1 = bus_cmd;
        n++;
        bus_gnt = 1'b1; bus_shared_in = sh;
        #1;
      end
      if (cpu_done) begin done = 1'b1; cyc = k + 1; end
      @(negedge clk);
      bus_gnt = 1'b0; bus_shared_in = 1'b0;
    end
    cpu_valid = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, output logic [2:0] r);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1;
    r = {snp_shared, snp_supply, snp_mem_wb};
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, cyc;
    logic [1:0] c0, c1;
    logic [AW-1:0] a0;
    logic [2:0] r;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset outputs
    chk(!bus_req && !cpu_done, "R1 idle outputs", {bus_req, cpu_done}, 0);
    chk({snp_shared, snp_supply, snp_mem_wb} == 3'b000, "R1 snoop outputs",
        {snp_shared, snp_supply, snp_mem_wb}, 0);
    snoop(C_RD, 12'h007, r);
    chk(r == 3'b000, "R1 snoop on reset line", r, 0);
    cpu_op(1'b0, 12'h007, 1'b0, n, c0, c1, a0, cyc);
    chk(n == 1 && c0 == C_RD, "R1 invalid after reset forces read", {n, c0}, {1, C_RD});

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      if (v[37:36] == OP_SN) begin
        snoop(v[35:34], v[33:22], r);
        chk(r == v[2:0], $sformatf("R8/R9/R10 snoop response vec %0d", i), r, v[2:0]);
      end else begin
        cpu_op(v[36], v[33:22], v[21], n, c0, c1, a0, cyc);
        chk(n == int'(v[20:19]), $sformatf("R2-R7 bus count vec %0d", i), n, v[20:19]);
        if (v[20:19] != 0) begin
          chk(c0 == v[18:17] && a0 == v[14:3], $sformatf("R2 R5 R6 R7 first cmd vec %0d", i),
              {c0, a0}, {v[18:17], v[14:3]});
        end else begin
          chk(cyc == 1, $sformatf("R3 R4 same-cycle completion vec %0d", i), cyc, 1);
        end
        if (v[20:19] == 2)
          chk(c1 == v[16:15], $sformatf("R7 second cmd vec %0d", i), c1, v[16:15]);
        chk(cyc != 0, $sformatf("R2 done seen vec %0d", i), cyc, 1);
      end
    end

    // R11 / R12: pending invalidate converted by snoop
    cpu_op(1'b0, 12'h016, 1'b1, n, c0, c1, a0, cyc);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 12'h016;
    #1;
    chk(!bus_req && !cpu_done, "R12 no request in lookup cycle", {bus_req, cpu_done}, 0);
    @(negedge clk); #1;
    chk(bus_req && bus_cmd == C_INV, "R5 invalidate raised", {bus_req, bus_cmd}, {1'b1, C_INV});
    snp_valid = 1'b1; snp_cmd = C_RDX; snp_addr = 12'h016;
    #1;
    chk(!snp_supply && !snp_shared, "R9 clean line no supply", {snp_shared, snp_supply}, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(bus_req, "R12 request held without grant", bus_req, 1);
    chk(bus_cmd == C_RDX, "R11 upgrade becomes ownership read", bus_cmd, C_RDX);
    bus_gnt = 1'b1;
    #1;
    chk(cpu_done, "R11 done on grant", cpu_done, 1);
    @(negedge clk);
    bus_gnt = 1'b0; cpu_valid = 1'b0;
    snoop(C_RD, 12'h016, r);
    chk(r == 3'b011, "R11 line ends modified", r, 3'b011);

    // R13: snoop in same cycle blocks completion
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 12'h010;
    snp_valid = 1'b1; snp_cmd = C_RD; snp_addr = 12'h001;
    #1;
    chk(!cpu_done, "R13 blocked by snoop", cpu_done, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(cpu_done && !bus_req, "R13 completes after snoop", {cpu_done, bus_req}, 2'b10);
    @(negedge clk);
    cpu_valid = 1'b0;

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule